// File: doc/BRIEF.md
# Seconds Real-Time Clock with Match Alarm

This block is a real-time-clock peripheral on a simple memory-mapped register bus. A 32-bit seconds counter runs all the time and advances by one on each cycle where a one-cycle seconds strobe is high. Software can overwrite the counter through a load register and program a 32-bit match value. When the counter and the match value become equal, a raw alarm flag is set.

A one-bit mask gates the raw flag onto the interrupt output and into a masked status read. A write of any data to the clear offset drops the raw flag. A constant identification window near the top of a 4 KB space returns eight bytes, one per word, so that software can recognise the block.

Bus writes take effect on the clock edge where `bus_sel` and `bus_wr` are both high. Reads are combinational from registered state while `bus_sel` is high and `bus_wr` is low.

Top module: `secs_rtc`

## Requirements
- R1: After reset, reads of offsets 0x00 (count), 0x04 (match), 0x08 (load), 0x10 (mask), 0x14 (raw) and 0x18 (masked) return 0, and `alarm_irq` is 0.
- R2: A cycle with `tick` high and no load write adds one to the count, modulo 2^32. The new value is readable at 0x00 after that clock edge.
- R3: A write to 0x08 sets the count to the written data at that edge, and this wins over a `tick` in the same cycle. A read of 0x08 returns the last value written there.
- R4: Offset 0x0C always reads 1, and writes to it change nothing.
- R5: A write to 0x10 stores bit 0 of the data, and a read of 0x10 returns that bit in bit 0 with all other bits zero.
- R6: A read of 0x18 returns raw AND mask in bit 0, and `alarm_irq` equals that same value in every cycle.
- R7: A write of any data to 0x1C clears the raw flag at that edge. A read of 0x1C returns 0.
- R8: When a tick brings the count equal to the match value, the raw flag (0x14 bit 0) is 1 after the same edge that updates the count.
- R9: A write to 0x04 or to 0x08 that makes the count and the match value equal sets the raw flag at that same edge, with no tick needed. If such an event and a clear write fall in the same cycle, the set wins.
- R10: A match value below the current count fires only after the count wraps from 0xFFFFFFFF through 0.
- R11: Reads of 0xFE0 + 4*i for i = 0..7 return, in order, 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R12: Writes to 0x00, 0x14, 0x18 and to any undecoded offset change no state. Undecoded offsets, and any cycle that is not a read, return 0 on `bus_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle seconds strobe |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| alarm_irq | output | 1 | Masked alarm interrupt |

## Verification
Every register in the block updates at the edge that samples its write or tick. Read data and the interrupt therefore show a write or tick from cycle N during cycle N+1. That includes an alarm raised by a load or match write, which adds no further cycle of delay. The bench drives its inputs just after a falling edge and holds them for a full period. One time unit later it compares `bus_rdata` and `alarm_irq` against a behavioural model that the rising edge has advanced. Because the comparison runs on every cycle, a result that arrives a cycle early or late shows up as a mismatch.

// File: rtl/secs_rtc_pkg.sv
package secs_rtc_pkg;
  localparam int RTC_AW = 12;
  localparam int RTC_DW = 32;
  localparam int ID_LEN = 8;

  localparam logic [RTC_AW-1:0] OFS_COUNT  = 12'h000;
  localparam logic [RTC_AW-1:0] OFS_MATCH  = 12'h004;
  localparam logic [RTC_AW-1:0] OFS_LOAD   = 12'h008;
  localparam logic [RTC_AW-1:0] OFS_CTRL   = 12'h00C;
  localparam logic [RTC_AW-1:0] OFS_MASK   = 12'h010;
  localparam logic [RTC_AW-1:0] OFS_RAW    = 12'h014;
  localparam logic [RTC_AW-1:0] OFS_MSKD   = 12'h018;
  localparam logic [RTC_AW-1:0] OFS_CLEAR  = 12'h01C;
  localparam logic [RTC_AW-1:0] OFS_IDBASE = 12'hFE0;

  typedef enum logic [3:0] {
    RG_COUNT, RG_MATCH, RG_LOAD, RG_CTRL, RG_MASK,
    RG_RAW, RG_MSKD, RG_CLEAR, RG_ID, RG_NONE
  } rtc_reg_e;

  function automatic rtc_reg_e rtc_decode(input logic [RTC_AW-1:0] a);
    rtc_reg_e r;
    case (a)
      OFS_COUNT: r = RG_COUNT;
      OFS_MATCH: r = RG_MATCH;
      OFS_LOAD:  r = RG_LOAD;
      OFS_CTRL:  r = RG_CTRL;
      OFS_MASK:  r = RG_MASK;
      OFS_RAW:   r = RG_RAW;
      OFS_MSKD:  r = RG_MSKD;
      OFS_CLEAR: r = RG_CLEAR;
      default:   r = (a >= OFS_IDBASE && a[1:0] == 2'b00) ? RG_ID : RG_NONE;
    endcase
    return r;
  endfunction

  function automatic logic [7:0] rtc_id_byte(input logic [2:0] idx);
    logic [7:0] b;
    case (idx)
      3'd0: b = 8'h31;
      3'd1: b = 8'h10;
      3'd2: b = 8'h14;
      3'd3: b = 8'h00;
      3'd4: b = 8'h0D;
      3'd5: b = 8'hF0;
      3'd6: b = 8'h05;
      default: b = 8'hB1;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/secs_rtc_counter.sv
module secs_rtc_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load_we,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_d,
  output logic             cnt_chg,
  output logic [CNT_W-1:0] load_q
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] load_d;

  always_comb begin
    cnt_chg = load_we | tick;
    cnt_d   = cnt_q;
    if (load_we)   cnt_d = load_val;
    else if (tick) cnt_d = cnt_q + ONE;
    load_d  = load_we ? load_val : load_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      load_q <= '0;
    end else begin
      if (cnt_chg) cnt_q  <= cnt_d;
      if (load_we) load_q <= load_d;
    end
  end

  p_tick_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load_we) |=> (cnt_q == $past(cnt_q) + ONE));

  p_load_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_we |=> (cnt_q == $past(load_val) && load_q == $past(load_val)));
endmodule

// File: rtl/secs_rtc_alarm.sv
module secs_rtc_alarm #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic [CNT_W-1:0] cnt_d,
  input  logic             cnt_chg,
  input  logic             match_we,
  input  logic [CNT_W-1:0] match_val,
  input  logic             mask_we,
  input  logic             mask_val,
  input  logic             clr_we,
  output logic [CNT_W-1:0] match_q,
  output logic             mask_q,
  output logic             raw_q,
  output logic             alarm_irq
);
  logic [CNT_W-1:0] match_d;
  logic             mask_d;
  logic             raw_d;
  logic             hit;

  always_comb begin
    match_d = match_we ? match_val : match_q;
    mask_d  = mask_we ? mask_val : mask_q;
    hit     = (cnt_chg | match_we) && (cnt_d == match_d);
    if (hit)         raw_d = 1'b1;
    else if (clr_we) raw_d = 1'b0;
    else             raw_d = raw_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= '0;
      mask_q  <= 1'b0;
      raw_q   <= 1'b0;
    end else begin
      if (match_we) match_q <= match_d;
      if (mask_we)  mask_q  <= mask_d;
      raw_q <= raw_d;
    end
  end

  assign alarm_irq = raw_q & mask_q;

  p_mask_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (mask_q == $past(mask_val)));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !cnt_chg && !match_we) |=> !raw_q);

  p_rise_on_equal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_q) |-> (cnt_q == match_q));
endmodule

// File: rtl/secs_rtc_regif.sv
module secs_rtc_regif
  import secs_rtc_pkg::*;
(
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [RTC_AW-1:0] bus_addr,
  input  logic [RTC_DW-1:0] bus_wdata,
  input  logic [RTC_DW-1:0] cnt_q,
  input  logic [RTC_DW-1:0] match_q,
  input  logic [RTC_DW-1:0] load_q,
  input  logic              mask_q,
  input  logic              raw_q,
  output logic              load_we,
  output logic              match_we,
  output logic              mask_we,
  output logic              clr_we,
  output logic [RTC_DW-1:0] bus_rdata
);
  localparam int IDX_LSB = 2;
  localparam int IDX_W   = $clog2(ID_LEN);

  rtc_reg_e         rsel;
  logic             wr_stb;
  logic             rd_stb;
  logic [IDX_W-1:0] id_idx;

  always_comb begin
    rsel     = rtc_decode(bus_addr);
    wr_stb   = bus_sel & bus_wr;
    rd_stb   = bus_sel & ~bus_wr;
    id_idx   = bus_addr[IDX_LSB +: IDX_W];
    load_we  = wr_stb && (rsel == RG_LOAD);
    match_we = wr_stb && (rsel == RG_MATCH);
    mask_we  = wr_stb && (rsel == RG_MASK);
    clr_we   = wr_stb && (rsel == RG_CLEAR);
    bus_rdata = '0;
    if (rd_stb) begin
      case (rsel)
        RG_COUNT: bus_rdata = cnt_q;
        RG_MATCH: bus_rdata = match_q;
        RG_LOAD:  bus_rdata = load_q;
        RG_CTRL:  bus_rdata = RTC_DW'(1);
        RG_MASK:  bus_rdata = RTC_DW'(mask_q);
        RG_RAW:   bus_rdata = RTC_DW'(raw_q);
        RG_MSKD:  bus_rdata = RTC_DW'(raw_q & mask_q);
        RG_ID:    bus_rdata = RTC_DW'(rtc_id_byte(id_idx));
        default:  bus_rdata = '0;
      endcase
    end
  end

  always_comb begin
    p_one_strobe_r12: assert ($countones({load_we, match_we, mask_we, clr_we}) <= 1);
  end
endmodule

// File: rtl/secs_rtc.sv
module secs_rtc
  import secs_rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [RTC_AW-1:0] bus_addr,
  input  logic [RTC_DW-1:0] bus_wdata,
  output logic [RTC_DW-1:0] bus_rdata,
  output logic              alarm_irq
);
  logic [RTC_DW-1:0] cnt_q, cnt_d, load_q, match_q;
  logic              cnt_chg, load_we, match_we, mask_we, clr_we, mask_q, raw_q;

  secs_rtc_regif u_regif (
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .cnt_q    (cnt_q),
    .match_q  (match_q),
    .load_q   (load_q),
    .mask_q   (mask_q),
    .raw_q    (raw_q),
    .load_we  (load_we),
    .match_we (match_we),
    .mask_we  (mask_we),
    .clr_we   (clr_we),
    .bus_rdata(bus_rdata)
  );

  secs_rtc_counter #(.CNT_W(RTC_DW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .load_we (load_we),
    .load_val(bus_wdata),
    .cnt_q   (cnt_q),
    .cnt_d   (cnt_d),
    .cnt_chg (cnt_chg),
    .load_q  (load_q)
  );

  secs_rtc_alarm #(.CNT_W(RTC_DW)) u_alarm (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_q    (cnt_q),
    .cnt_d    (cnt_d),
    .cnt_chg  (cnt_chg),
    .match_we (match_we),
    .match_val(bus_wdata),
    .mask_we  (mask_we),
    .mask_val (bus_wdata[0]),
    .clr_we   (clr_we),
    .match_q  (match_q),
    .mask_q   (mask_q),
    .raw_q    (raw_q),
    .alarm_irq(alarm_irq)
  );

  p_irq_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq |-> (mask_q && raw_q));
endmodule

// File: tb/sim_secs_rtc.sv
module sim_secs_rtc;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        alarm_irq;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    n_cyc = 0;
  string req = "R1";
  bit    done = 1'b0;

  logic [31:0] m_cnt, m_match, m_load;
  logic        m_mask, m_raw;

  always #(CLK_PERIOD/2) clk = ~clk;

  secs_rtc u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .alarm_irq(alarm_irq)
  );

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    logic [31:0] nc, nm;
    bit wr, ev;
    if (!rst_n) begin
      m_cnt = 0; m_match = 0; m_load = 0; m_mask = 0; m_raw = 0;
    end else begin
      wr = bus_sel && bus_wr;
      nc = m_cnt; nm = m_match; ev = tick;
      if (tick) nc = m_cnt + 1;
      if (wr && bus_addr == 12'h008) begin nc = bus_wdata; m_load = bus_wdata; ev = 1; end
      if (wr && bus_addr == 12'h004) begin nm = bus_wdata; ev = 1; end
      if (wr && bus_addr == 12'h010) m_mask = bus_wdata[0];
      if (wr && bus_addr == 12'h01C) m_raw = 0;
      if (ev && nc == nm) m_raw = 1;
      m_cnt = nc; m_match = nm;
    end
  end

  function automatic logic [31:0] exp_read();
    logic [7:0] ids [8] = '{8'h31, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    if (!(bus_sel && !bus_wr)) return 0;
    case (bus_addr)
      12'h000: return m_cnt;
      12'h004: return m_match;
      12'h008: return m_load;
      12'h00C: return 1;
      12'h010: return {31'd0, m_mask};
      12'h014: return {31'd0, m_raw};
      12'h018: return {31'd0, m_raw & m_mask};
      default: begin
        if (bus_addr >= 12'hFE0 && bus_addr[1:0] == 2'b00) return {24'd0, ids[bus_addr[4:2]]};
        return 0;
      end
    endcase
  endfunction

  task automatic compare();
    logic [31:0] er;
    logic ei;
    er = exp_read();
    ei = m_raw & m_mask;
    n_cmp++;
    if (bus_rdata !== er || alarm_irq !== ei) begin
      n_bad++;
      $display("FAIL %s addr=%h rdata=%h exp=%h irq=%b exp=%b",
               req, bus_addr, bus_rdata, er, alarm_irq, ei);
    end
  endtask

  // drive for one cycle, compare mid-cycle
  task automatic cyc(input bit t, input bit s, input bit w, input logic [11:0] a,
                     input logic [31:0] d);
    tick = t; bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
    #1;
    compare();
    @(negedge clk);
  endtask

  task automatic rd(input logic [11:0] a);
    cyc(0, 1, 0, a, 32'h0);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    cyc(0, 1, 1, a, d);
  endtask

  task automatic tk(input logic [11:0] a);
    cyc(1, 1, 0, a, 32'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc > WATCHDOG) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired after %0d cycles, expected end before %0d", n_cyc, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    req = "R1";
    rd(12'h000); rd(12'h004); rd(12'h008); rd(12'h010); rd(12'h014); rd(12'h018);
    // R4: control reads 1, writes ignored
    req = "R4";
    rd(12'h00C); wr(12'h00C, 32'h0); rd(12'h00C); wr(12'h00C, 32'hFFFF_FFFF); rd(12'h00C);
    // R2: increments on tick
    req = "R2";
    tk(12'h000); tk(12'h000); cyc(0, 0, 0, 12'h000, 0); tk(12'h000); rd(12'h000);
    // R3: load wins over tick, readback
    req = "R3";
    cyc(1, 1, 1, 12'h008, 32'h0000_0100); rd(12'h000); rd(12'h008); tk(12'h000); rd(12'h008);
    // R5: mask holds bit 0
    req = "R5";
    wr(12'h010, 32'hFFFF_FFFE); rd(12'h010); wr(12'h010, 32'h0000_0003); rd(12'h010);
    // R8 / R6: count reaches match on ticks
    req = "R8";
    wr(12'h004, 32'h0000_0104); rd(12'h004);
    for (int i = 0; i < 4; i++) tk(12'h014);
    rd(12'h014);
    req = "R6";
    rd(12'h018); wr(12'h010, 32'h0); rd(12'h018); wr(12'h010, 32'h1); rd(12'h018);
    // R7: clear by any data, clear offset reads 0
    req = "R7";
    wr(12'h01C, 32'h0); rd(12'h014); rd(12'h01C); tk(12'h014); rd(12'h018);
    // R9: load or match write that makes them equal sets raw at once
    req = "R9";
    wr(12'h008, 32'h0000_0104); rd(12'h014); wr(12'h01C, 32'h5A5A_0000); rd(12'h014);
    wr(12'h004, 32'h0000_0104); rd(12'h014); wr(12'h01C, 32'h1);
    cyc(1, 1, 1, 12'h01C, 32'h0); rd(12'h014);
    wr(12'h004, 32'h0000_0200); wr(12'h01C, 32'h1); rd(12'h014);
    // R10: wrap before firing
    req = "R10";
    wr(12'h008, 32'hFFFF_FFFE); wr(12'h004, 32'h0000_0001); rd(12'h014);
    tk(12'h014); tk(12'h000); rd(12'h014); tk(12'h014); rd(12'h000); rd(12'h018);
    // R11: identification bytes
    req = "R11";
    for (int i = 0; i < 8; i++) rd(12'hFE0 + 12'(4 * i));
    // R12: ignored writes, undecoded reads 0
    req = "R12";
    wr(12'h01C, 32'h0);
    wr(12'h000, 32'h1234_5678); rd(12'h000);
    wr(12'h014, 32'h1); rd(12'h014);
    wr(12'h018, 32'h1); rd(12'h018);
    wr(12'h020, 32'hDEAD_BEEF); rd(12'h020); rd(12'h004); rd(12'h008); rd(12'h010);
    rd(12'h002); rd(12'h800);
    cyc(0, 0, 0, 12'h000, 0);
    finish_run();
  end
endmodule